// File: doc/BRIEF.md
# SPI Flash Master Shift Engine

This block is the serial core of a single-lane SPI master meant for flash memories. Software programs a 32-bit configuration word and a one-bit controller enable, then pushes 32-bit words into a small transmit queue. For each queued word the engine drives 32 bits on MOSI, most significant bit first, and in the same transfer collects 32 bits from MISO. The collected word appears on the receive port with a one-cycle valid pulse. Every transmitted word therefore returns exactly one received word, including words that only carry command, address or dummy bytes. When a flash address is packed into a word, it goes out most significant byte first and uses at most three bytes.

The serial clock runs at the reference clock divided by a power of two, chosen by a 3-bit code. Polarity and phase select one of the four usual SPI modes. Chip selects are active low and come straight from a field of the configuration word. The field can drive the pins only while the engine is busy, or all the time when manual chip select is on. The field holds across back-to-back words, so a multi-word flash command stays inside one select window. An optional manual-start mode holds queued words until software writes a start bit. The engine clears that bit itself once it has drained the queue.

Top module: `spi_flash_engine`

## Requirements
- R1: After reset, `sclk` is 0, every `csN` bit is 1, `busy` and `rxValid` are 0, `txReady` is 1 and `cfgRdata` reads 0.
- R2: A word leaves the queue only when three things hold: the enable register bit (written through `enWe`/`enBit`) is 1, configuration bit 0 (master enable) is 1, and the queue is not empty. Otherwise `busy` stays 0 and no serial clock edge occurs.
- R3: Each queued word is shifted out on `mosi` MSB first over 32 serial clock cycles. Exactly one `rxValid` pulse follows it, and `rxData` holds the 32 bits sampled from `miso` during that word, the first sampled bit in bit 31.
- R4: Configuration bits 5:3 hold a code c from 0 to 7. Within a word, consecutive `sclk` transitions are 2^c reference clock cycles apart, so the serial clock period is 2^(c+1) cycles.
- R5: Configuration bit 1 sets the idle level of `sclk`. While the engine is idle, `sclk` follows that bit one cycle after it is written.
- R6: Configuration bit 2 selects the phase. With 0, each bit is on `mosi` before the leading edge and `miso` is sampled on leading edges. With 1, `mosi` changes on leading edges and `miso` is sampled on trailing edges.
- R7: Configuration bits 10 and up (one per chip select, active low; device k is selected by writing the inverse of 1<<k) drive `csN` while `busy` is 1. With configuration bit 14 set, they drive `csN` at all times. In the other cases `csN` is all ones. Between back-to-back words, `csN` does not return high.
- R8: With configuration bit 15 set, no word starts until configuration bit 16 reads 1. Bit 16 clears itself when a word completes and the queue is empty.
- R9: The queue holds TX_DEPTH words. `txReady` is 0 while it is full, and words are transmitted in the order they were pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgWdata | input | 32 | Configuration write value |
| cfgRdata | output | 32 | Current configuration value |
| enWe | input | 1 | Enable register write strobe |
| enBit | input | 1 | Enable register write value |
| txValid | input | 1 | Push a word into the transmit queue |
| txData | input | 32 | Word to transmit |
| txReady | output | 1 | Queue can take a word |
| rxValid | output | 1 | One-cycle pulse with a received word |
| rxData | output | 32 | Received word |
| busy | output | 1 | A word is being shifted |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csN | output | NCS | Active-low chip selects |

## Verification
The assertions check on every cycle the properties that hold at the ports at all times. Chip selects are all high while idle in automatic mode and equal the programmed field while busy or in manual mode. An idle engine with master enable clear, or waiting for its start bit, does not become busy. `rxValid` never lasts two cycles. The idle serial clock follows the polarity bit. Only the bench's scenarios can show the rest, using a slave model that samples and drives the serial lines in each mode. They show bit order and content in both directions, the edge spacing for several divisor codes, the phase behaviour, the select level held across back-to-back words, queue ordering and full back-pressure, and the self-clearing start bit.

// File: rtl/spi_flash_pkg.sv
package spi_flash_pkg;
  // configuration word field positions (decoded by the control block)
  localparam int BIT_MEN      = 0;
  localparam int BIT_CPOL     = 1;
  localparam int BIT_CPHA     = 2;
  localparam int DIV_LSB      = 3;
  localparam int DIV_W        = 3;
  localparam int CS_LSB       = 10;
  localparam int BIT_MANCS    = 14;
  localparam int BIT_MANSTART = 15;
  localparam int BIT_START    = 16;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} engState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // take a new word into the shifter
    logic tick;    // serial clock transition this cycle
    logic sample;  // capture miso at this transition
    logic shift;   // advance mosi at this transition
    logic finish;  // word complete, publish received word
  } engStrobe_t;
endpackage

// File: rtl/spi_flash_txq.sv
module spi_flash_txq #(
  parameter int DEPTH = 4,
  parameter int W     = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic [W-1:0] pushData,
  input  logic         pop,
  output logic [W-1:0] headData,
  output logic         empty,
  output logic         full
);
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic             doPush, doPop;

  assign empty    = (count == '0);
  assign full     = (count == CNT_W'(DEPTH));
  assign doPush   = push && !full;
  assign doPop    = pop && !empty;
  assign headData = mem[rdPtr];

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      if (doPush && !doPop)      count <= count + 1'b1;
      else if (doPop && !doPush) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end
endmodule

// File: rtl/spi_flash_ctrl.sv
module spi_flash_ctrl
  import spi_flash_pkg::*;
#(
  parameter int NCS    = 2,
  parameter int WORD_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [31:0]      cfgWdata,
  input  logic             enWe,
  input  logic             enBit,
  input  logic             qEmpty,
  output logic [31:0]      cfgQ,
  output engStrobe_t       stb,
  output logic             busy,
  output logic [NCS-1:0]   csN
);
  localparam int EDGES    = 2 * WORD_W;
  localparam int EDGE_W   = $clog2(EDGES);
  localparam int DIVCNT_W = 2 ** DIV_W;

  engState_t             state;
  logic                  enQ;
  logic [EDGE_W-1:0]     edgeCnt;
  logic [DIVCNT_W-1:0]   divCnt, halfLim;
  logic                  go, clearStart, cpha;

  assign cpha    = cfgQ[BIT_CPHA];
  assign halfLim = DIVCNT_W'(1) << cfgQ[DIV_LSB +: DIV_W];
  assign busy    = (state != ST_IDLE);
  assign go      = enQ && cfgQ[BIT_MEN] && !qEmpty &&
                   (!cfgQ[BIT_MANSTART] || cfgQ[BIT_START]);

  always_comb begin
    stb        = '0;
    stb.load   = go && (state == ST_IDLE || state == ST_DONE);
    stb.tick   = (state == ST_RUN) && (divCnt == halfLim - 1'b1);
    // even transitions are leading edges
    stb.sample = stb.tick && (edgeCnt[0] == cpha);
    stb.shift  = stb.tick && (edgeCnt[0] != cpha);
    stb.finish = (state == ST_DONE);
  end

  assign clearStart = (state == ST_DONE) && !stb.load && qEmpty;
  assign csN = (busy || cfgQ[BIT_MANCS]) ? cfgQ[CS_LSB +: NCS] : '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= '0;
      enQ  <= 1'b0;
    end else begin
      if (enWe) enQ <= enBit;
      if (cfgWe)           cfgQ <= cfgWdata;
      else if (clearStart) cfgQ[BIT_START] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      edgeCnt <= '0;
      divCnt  <= '0;
    end else if (stb.load) begin
      state   <= ST_RUN;
      edgeCnt <= '0;
      divCnt  <= '0;
    end else begin
      case (state)
        ST_RUN: begin
          if (stb.tick) begin
            divCnt  <= '0;
            edgeCnt <= edgeCnt + 1'b1;
            if (edgeCnt == EDGE_W'(EDGES - 1)) state <= ST_DONE;
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_flash_dp.sv
module spi_flash_dp
  import spi_flash_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  engStrobe_t        stb,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              busy,
  input  logic [WORD_W-1:0] txWord,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              rxValid,
  output logic [WORD_W-1:0] rxData
);
  logic [WORD_W-1:0] txSh, rxSh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclk    <= 1'b0;
      mosi    <= 1'b0;
      txSh    <= '0;
      rxSh    <= '0;
      rxValid <= 1'b0;
      rxData  <= '0;
    end else begin
      rxValid <= stb.finish;
      if (stb.finish) rxData <= rxSh;
      if (stb.load) begin
        sclk <= cpol;
        if (!cpha) begin
          mosi <= txWord[WORD_W-1];
          txSh <= txWord << 1;
        end else begin
          txSh <= txWord;
        end
      end else if (stb.tick) begin
        sclk <= ~sclk;
        if (stb.sample) rxSh <= {rxSh[WORD_W-2:0], miso};
        if (stb.shift) begin
          mosi <= txSh[WORD_W-1];
          txSh <= txSh << 1;
        end
      end else if (!busy) begin
        sclk <= cpol;
      end
    end
  end
endmodule

// File: rtl/spi_flash_engine.sv
module spi_flash_engine
  import spi_flash_pkg::*;
#(
  parameter int NCS      = 2,
  parameter int TX_DEPTH = 4
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           cfgWe,
  input  logic [31:0]    cfgWdata,
  output logic [31:0]    cfgRdata,
  input  logic           enWe,
  input  logic           enBit,
  input  logic           txValid,
  input  logic [31:0]    txData,
  output logic           txReady,
  output logic           rxValid,
  output logic [31:0]    rxData,
  output logic           busy,
  output logic           sclk,
  output logic           mosi,
  input  logic           miso,
  output logic [NCS-1:0] csN
);
  localparam int WORD_W = 32;

  engStrobe_t        stb;
  logic              qEmpty, qFull;
  logic [WORD_W-1:0] headWord;

  assign txReady = !qFull;

  spi_flash_txq #(.DEPTH(TX_DEPTH), .W(WORD_W)) u_txq (
    .clk(clk), .rstN(rstN), .push(txValid), .pushData(txData),
    .pop(stb.load), .headData(headWord), .empty(qEmpty), .full(qFull)
  );

  spi_flash_ctrl #(.NCS(NCS), .WORD_W(WORD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata),
    .enWe(enWe), .enBit(enBit), .qEmpty(qEmpty), .cfgQ(cfgRdata),
    .stb(stb), .busy(busy), .csN(csN)
  );

  spi_flash_dp #(.WORD_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cpol(cfgRdata[BIT_CPOL]),
    .cpha(cfgRdata[BIT_CPHA]), .busy(busy), .txWord(headWord),
    .miso(miso), .sclk(sclk), .mosi(mosi), .rxValid(rxValid),
    .rxData(rxData)
  );
endmodule

// File: rtl/spi_flash_sva.sv
module spi_flash_sva
  import spi_flash_pkg::*;
#(
  parameter int NCS = 2
) (
  input logic           clk,
  input logic           rstN,
  input logic           busy,
  input logic           sclk,
  input logic           rxValid,
  input logic [31:0]    cfgRdata,
  input logic [NCS-1:0] csN
);
  // R7: automatic select mode releases every select while idle
  a_r7_cs_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !cfgRdata[BIT_MANCS]) |-> (csN == '1));

  // R7: programmed field on the pins while busy or in manual mode
  a_r7_cs_field: assert property (@(posedge clk) disable iff (!rstN)
    (busy || cfgRdata[BIT_MANCS]) |-> (csN == cfgRdata[CS_LSB +: NCS]));

  // R2: master enable clear keeps an idle engine idle
  a_r2_no_start: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !cfgRdata[BIT_MEN]) |=> !busy);

  // R8: manual start armed without the start bit keeps the engine idle
  a_r8_wait_start: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cfgRdata[BIT_MANSTART] && !cfgRdata[BIT_START]) |=> !busy);

  // R3: one pulse per received word
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  // R5: idle serial clock sits at the polarity bit
  a_r5_idle_level: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && $past(!busy) && $stable(cfgRdata[BIT_CPOL])) |-> (sclk == cfgRdata[BIT_CPOL]));
endmodule

bind spi_flash_engine spi_flash_sva #(.NCS(NCS)) u_sva (
  .clk(clk), .rstN(rstN), .busy(busy), .sclk(sclk), .rxValid(rxValid),
  .cfgRdata(cfgRdata), .csN(csN)
);

// File: tb/test_spi_flash_engine.sv
module test_spi_flash_engine;
  localparam int NCS   = 2;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [31:0] cfgWdata = '0;
  logic [31:0] cfgRdata;
  logic enWe = 1'b0;
  logic enBit = 1'b0;
  logic txValid = 1'b0;
  logic [31:0] txData = '0;
  logic txReady, rxValid, busy, sclk, mosi;
  logic [31:0] rxData;
  logic miso = 1'b0;
  logic [NCS-1:0] csN;

  int checks = 0;
  int errors = 0;
  logic [31:0] expTx[$];
  logic [31:0] expRx[$];
  logic [31:0] respQ[$];

  bit cpolExp = 0, cphaExp = 0, b2b = 0;
  int halfExp = 1;
  logic [NCS-1:0] csExp = '1;

  always #4 clk = ~clk;

  spi_flash_engine #(.NCS(NCS), .TX_DEPTH(DEPTH)) i_spi_flash_engine (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata), .enWe(enWe), .enBit(enBit), .txValid(txValid),
    .txData(txData), .txReady(txReady), .rxValid(rxValid), .rxData(rxData),
    .busy(busy), .sclk(sclk), .mosi(mosi), .miso(miso), .csN(csN)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkCfg(bit men, bit cpol, bit cpha, int code,
                                        int dev, bit mancs, bit manst, bit st);
    logic [31:0] v;
    logic [NCS-1:0] sel;
    v = '0;
    sel = NCS'(1) << dev;
    v[0] = men; v[1] = cpol; v[2] = cpha; v[5:3] = code[2:0];
    v[10 +: NCS] = ~sel;
    v[14] = mancs; v[15] = manst; v[16] = st;
    return v;
  endfunction

  task automatic writeCfg(input logic [31:0] v);
    @(negedge clk);
    cfgWe = 1'b1; cfgWdata = v;
    cpolExp = v[1]; cphaExp = v[2]; halfExp = 1 << v[5:3]; csExp = v[10 +: NCS];
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic writeEn(input bit b);
    @(negedge clk);
    enWe = 1'b1; enBit = b;
    @(negedge clk);
    enWe = 1'b0;
  endtask

  // driver: queue expected items then push the word
  task automatic pushWord(input logic [31:0] tx, input logic [31:0] resp);
    expTx.push_back(tx);
    expRx.push_back(resp);
    respQ.push_back(resp);
    @(negedge clk);
    while (!txReady) @(negedge clk);
    txValid = 1'b1; txData = tx;
    @(negedge clk);
    txValid = 1'b0;
  endtask

  task automatic waitDone();
    for (int i = 0; i < 60000; i++) begin
      @(negedge clk);
      if (expRx.size() == 0 && respQ.size() == 0 && !busy) break;
    end
    repeat (3) @(negedge clk);
  endtask

  // slave model and mosi/edge monitor
  bit prevSclk = 0, csBad = 0, divBad = 0;
  int cyc = 0, nb = 0, edgeIdx = 0;
  logic [31:0] bits = '0;
  always @(negedge clk) begin
    if (!rstN) begin
      prevSclk = 0; cyc = 0; nb = 0; edgeIdx = 0; csBad = 0; divBad = 0;
    end else begin
      cyc++;
      if (busy && sclk != prevSclk) begin
        bit lead;
        lead = (prevSclk == cpolExp);
        if (edgeIdx != 0 && cyc != halfExp) divBad = 1;
        if (csN != csExp) csBad = 1;
        cyc = 0;
        if (lead ^ cphaExp) begin
          bits = {bits[30:0], mosi};
          nb++;
          if (nb == 32) begin
            if (expTx.size() == 0) check(1'b0, "R3 unexpected mosi word", bits, 0);
            else begin
              check(bits == expTx[0], "R3/R6 mosi word", bits, expTx[0]);
              void'(expTx.pop_front());
            end
            check(!csBad, "R7 select held during word", 32'(csBad), 0);
            check(!divBad, "R4 edge spacing", 32'(divBad), 0);
            csBad = 0; divBad = 0; nb = 0;
            if (respQ.size() != 0) void'(respQ.pop_front());
          end
        end
        edgeIdx++;
        if (edgeIdx == 64) edgeIdx = 0;
      end
      prevSclk = sclk;
      miso = (respQ.size() != 0) ? respQ[0][31 - nb] : 1'b0;
    end
  end

  // monitor: received words against the scoreboard
  always @(negedge clk) begin
    if (rstN && rxValid) begin
      if (expRx.size() == 0) check(1'b0, "R3 unexpected rx word", rxData, 0);
      else begin
        check(rxData == expRx[0], "R3/R6 rx word", rxData, expRx[0]);
        void'(expRx.pop_front());
        if (b2b && expRx.size() != 0)
          check(busy && csN == csExp, "R7 select kept between words",
                32'(csN), 32'(csExp));
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(sclk == 1'b0, "R1 sclk", 32'(sclk), 0);
    check(csN == '1, "R1 csN", 32'(csN), 32'(2'b11));
    check(!busy && !rxValid, "R1 busy/rxValid", 32'({busy, rxValid}), 0);
    check(txReady, "R1 txReady", 32'(txReady), 1);
    check(cfgRdata == 0, "R1 cfgRdata", cfgRdata, 0);

    // R2: enable register clear blocks start
    writeCfg(mkCfg(1, 0, 0, 0, 0, 0, 0, 0));
    pushWord(32'hA5C3_0F1E, 32'h1234_5678);
    repeat (100) @(negedge clk);
    check(!busy, "R2 enable reg off busy", 32'(busy), 0);
    check(csN == '1, "R2 enable reg off csN", 32'(csN), 32'(2'b11));
    writeEn(1);
    waitDone();
    // R2: master enable clear blocks start
    writeCfg(mkCfg(0, 0, 0, 0, 1, 0, 0, 0));
    pushWord(32'h0302_0100, 32'hFFFF_0000);
    repeat (100) @(negedge clk);
    check(!busy, "R2 master enable off busy", 32'(busy), 0);
    writeCfg(mkCfg(1, 0, 0, 0, 1, 0, 0, 0));
    waitDone();
    check(csN == '1, "R7 auto select released when idle", 32'(csN), 32'(2'b11));

    // R5/R6: all four modes, back-to-back pairs
    for (int m = 0; m < 4; m++) begin
      writeEn(0);
      writeCfg(mkCfg(1, m[0], m[1], 1, m % 2, 0, 0, 0));
      repeat (3) @(negedge clk);
      check(sclk == m[0], "R5 idle sclk level", 32'(sclk), 32'(m[0]));
      b2b = 1;
      pushWord(32'h9E00_0000 ^ (m * 32'h1111_1111), 32'hC0DE_0000 + m);
      pushWord(32'h0123_4567 + m, 32'h8000_0001 << m);
      writeEn(1);
      waitDone();
      b2b = 0;
    end

    // R4: slower divisor codes
    writeCfg(mkCfg(1, 0, 0, 3, 0, 0, 0, 0));
    pushWord(32'hDEAD_BEEF, 32'h5A5A_A5A5);
    waitDone();
    writeCfg(mkCfg(1, 1, 1, 7, 0, 0, 0, 0));
    pushWord(32'h7000_0003, 32'h8000_0001);
    waitDone();

    // R7: manual select drives the field while idle
    writeCfg(mkCfg(1, 0, 0, 0, 1, 1, 0, 0));
    repeat (2) @(negedge clk);
    check(csN == 2'b01, "R7 manual select idle", 32'(csN), 32'(2'b01));
    pushWord(32'h0B00_1000, 32'h00FF_00FF);
    waitDone();
    check(csN == 2'b01, "R7 manual select after word", 32'(csN), 32'(2'b01));

    // R8: manual start
    writeCfg(mkCfg(1, 0, 0, 0, 0, 0, 1, 0));
    pushWord(32'h6B12_3456, 32'h2468_ACE0);
    repeat (100) @(negedge clk);
    check(!busy, "R8 waits for start bit", 32'(busy), 0);
    writeCfg(mkCfg(1, 0, 0, 0, 0, 0, 1, 1));
    repeat (2) @(negedge clk);
    check(busy, "R8 starts after start bit", 32'(busy), 1);
    check(cfgRdata[16], "R8 start bit held while running", 32'(cfgRdata[16]), 1);
    waitDone();
    check(!cfgRdata[16], "R8 start bit cleared", 32'(cfgRdata[16]), 0);

    // R9: fill the queue, then drain in order
    writeEn(0);
    writeCfg(mkCfg(1, 0, 1, 0, 0, 0, 0, 0));
    b2b = 1;
    for (int k = 0; k < DEPTH; k++)
      pushWord(32'h1000_0000 * (k + 1) + k, 32'hF0F0_0000 + k);
    @(negedge clk);
    check(!txReady, "R9 txReady low when full", 32'(txReady), 0);
    writeEn(1);
    waitDone();
    b2b = 0;
    check(txReady, "R9 txReady after drain", 32'(txReady), 1);
    check(expTx.size() == 0 && expRx.size() == 0, "R9 all words seen",
          32'(expTx.size() + expRx.size()), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule